// File: doc/BRIEF.md
# Peak Limiter Gain Sequencer

This block keeps an audio output out of clipping. It does this by adjusting the three gain settings that feed the tone and volume datapath: bass boost, treble boost and digital attenuation. A clip detector upstream raises a per-sample clip flag, and the block samples that flag on each sample strobe. While clipping persists, the block first takes tone boost away. Only when both boost levels have reached zero does it add attenuation, one dB code at a time.

When clipping ends, recovery runs in the opposite order. Attenuation returns to the programmed level first, and only then are bass and treble boost raised back toward their programmed levels. A 4-bit attack code paces the reduction steps and a 4-bit release code paces the recovery steps. A code k means one step per 2^k counted sample strobes. When limiting is disabled, the programmed values pass straight through to the outputs.

Top module: `peak_limiter_seq`

## Requirements
- R1: While `en_i` is 0, `bass_o`, `treb_o` and `att_o` equal `user_bass_i`, `user_treb_i` and `user_att_i` in the same cycle, and this includes cycles during reset.
- R2: While limiting on a sampled clip with either boost nonzero, each attack tick lowers every nonzero boost by one code, and attenuation does not change.
- R3: While limiting on a sampled clip with both boosts at zero, each attack tick raises attenuation by one code. Attenuation saturates at the maximum code of 2^ATT_W-1, which is 127 by default.
- R4: Reduction steps fall on every 2^k-th counted strobe, where k is `atk_rate_i`. For example, with k=2 the first step comes on the 4th strobe counted after limiting begins.
- R5: After clipping stops, attenuation steps down by one code per release tick until it reaches `user_att_i`, and the boost levels do not change while attenuation is above the user level.
- R6: Once attenuation is at the user level, each release tick raises each boost that is below its user level by one code. Bass and treble step together, and each stops at its own user level.
- R7: Recovery steps fall on every 2^k-th counted strobe, where k is `rel_rate_i`.
- R8: If clipping returns during recovery, reduction resumes from the current values. Any nonzero boost is lowered before any further attenuation is added.
- R9: The effective boosts never exceed their user levels, and effective attenuation never falls below `user_att_i`. After a change of a user value, the effective value is brought inside its bound on the next clock edge.
- R10: `done_o` is 1 exactly when all three outputs equal their user values and the most recently sampled clip flag is 0.
- R11: `clip_i` is captured on each strobe, and a strobe acts on the flag captured at the previous strobe. The step prescaler restarts whenever the operating phase changes, so every new phase begins with a full 2^k-strobe interval.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Synchronous active-low reset |
| en_i | input | 1 | Limiter enable |
| strobe_i | input | 1 | One-cycle sample strobe |
| clip_i | input | 1 | Clip flag for the current sample |
| user_bass_i | input | 4 | Programmed bass boost, dB codes |
| user_treb_i | input | 4 | Programmed treble boost, dB codes |
| user_att_i | input | 7 | Programmed attenuation, dB codes |
| atk_rate_i | input | 4 | Attack pacing code k (step per 2^k strobes) |
| rel_rate_i | input | 4 | Release pacing code k (step per 2^k strobes) |
| bass_o | output | 4 | Effective bass boost |
| treb_o | output | 4 | Effective treble boost |
| att_o | output | 7 | Effective attenuation |
| done_o | output | 1 | All values at user level and no clip sampled |

## Verification
Pass-through with the limiter disabled is combinational, so the bench checks it in the same cycle that the user inputs change. A gain step lands on the clock edge of the strobe that completes its prescaler interval. A phase change caused by that step is taken up on the idle cycle that follows, which is why every bench strobe lasts one cycle and is followed by at least one idle cycle. The bench computes its expected values by counting strobes: the first strobe of each stimulus still acts on the previously sampled clip flag, and each phase needs 2^k counted strobes before its first step. Every check is sampled at a falling edge one full cycle after the last strobe, when both the registered gains and `done_o` are settled.

// File: rtl/lim_pkg.sv
// Package: shared types for the peak limiter gain sequencer.
// Assumes: one limiter instance drives a single bass/treble/attenuation set.
package lim_pkg;

    // Operating phase of the limiter, in order of reduction priority.
    typedef enum logic [2:0] {
        PH_IDLE     = 3'd0,
        PH_CUT_TONE = 3'd1,
        PH_ADD_ATT  = 3'd2,
        PH_REL_ATT  = 3'd3,
        PH_REL_TONE = 3'd4
    } lim_phase_e;

    // True for the phases paced by the attack code.
    function automatic logic is_attack(input lim_phase_e ph);
        return (ph == PH_CUT_TONE) || (ph == PH_ADD_ATT);
    endfunction

endpackage

// File: rtl/lim_phase_sel.sv
// Module: lim_phase_sel
// Picks the operating phase from the sampled clip flag and the current
// effective gains versus the user gains. Purely combinational.
// Assumes: effective values are already within their bounds (see lanes).
module lim_phase_sel
    import lim_pkg::*;
#(
    parameter int BOOST_W   = 4,
    parameter int ATT_W     = 7,
    parameter int NUM_BOOST = 2
) (
    input  logic               en_i,
    input  logic               clip_q_i,
    input  logic [BOOST_W-1:0] boost_q_i    [NUM_BOOST],
    input  logic [BOOST_W-1:0] boost_user_i [NUM_BOOST],
    input  logic [ATT_W-1:0]   att_q_i,
    input  logic [ATT_W-1:0]   att_user_i,
    output lim_phase_e         phase_o
);

    logic any_boost;
    logic boost_low;

    // Summarise the boost lanes: any nonzero, any below its user level.
    always_comb begin
        any_boost = 1'b0;
        boost_low = 1'b0;
        for (int i = 0; i < NUM_BOOST; i++) begin
            if (boost_q_i[i] != '0)
                any_boost = 1'b1;
            if (boost_q_i[i] < boost_user_i[i])
                boost_low = 1'b1;
        end
    end

    // Phase priority: cut tone, add attenuation, release attenuation, release tone.
    always_comb begin
        if (!en_i)
            phase_o = PH_IDLE;
        else if (clip_q_i)
            phase_o = any_boost ? PH_CUT_TONE : PH_ADD_ATT;
        else if (att_q_i > att_user_i)
            phase_o = PH_REL_ATT;
        else if (boost_low)
            phase_o = PH_REL_TONE;
        else
            phase_o = PH_IDLE;
    end

endmodule

// File: rtl/lim_pacer.sv
// Module: lim_pacer
// Step prescaler. Counts sample strobes in the current phase and issues a
// one-cycle tick on every 2^k-th one, where k is the attack code in the
// reduction phases and the release code in the recovery phases. The count
// restarts on any phase change; a strobe arriving in the cycle of the
// change is not counted.
// Assumes: strobes are single-cycle pulses separated by at least one idle cycle.
module lim_pacer
    import lim_pkg::*;
#(
    parameter int RATE_W = 4
) (
    input  logic              clk,
    input  logic              rst_n,
    input  lim_phase_e        phase_i,
    input  logic              strobe_i,
    input  logic [RATE_W-1:0] atk_rate_i,
    input  logic [RATE_W-1:0] rel_rate_i,
    output logic              tick_o
);

    localparam int CNT_W = (1 << RATE_W) - 1;

    lim_phase_e        phase_q;
    logic [CNT_W-1:0]  cnt_q;
    logic [CNT_W-1:0]  limit;
    logic [RATE_W-1:0] rate_sel;
    logic              same_phase;

    // Choose the pacing code and build the 2^k-1 terminal count.
    always_comb begin
        rate_sel   = is_attack(phase_i) ? atk_rate_i : rel_rate_i;
        limit      = ~({CNT_W{1'b1}} << rate_sel);
        same_phase = (phase_i == phase_q);
        tick_o     = strobe_i && same_phase && (phase_i != PH_IDLE) && (cnt_q == limit);
    end

    // Track the phase and count strobes, restarting on each phase change.
    always_ff @(posedge clk) begin
        if (!rst_n) begin
            phase_q <= PH_IDLE;
            cnt_q   <= '0;
        end else if (!same_phase) begin
            phase_q <= phase_i;
            cnt_q   <= '0;
        end else if (strobe_i && (phase_i != PH_IDLE)) begin
            cnt_q <= (cnt_q == limit) ? '0 : cnt_q + 1'b1;
        end
    end

    // R11: a phase change always leaves the counter at zero.
    p_restart_r11: assert property (@(posedge clk) disable iff (!rst_n)
        (phase_i != phase_q) |=> (cnt_q == '0));

endmodule

// File: rtl/lim_boost_lane.sv
// Module: lim_boost_lane
// One tone-boost register. It steps down by one code on attack ticks in the
// cut-tone phase and up by one code on release ticks in the release-tone
// phase, and it is clamped so that it never exceeds the user level.
// Assumes: tick_i is at most one cycle wide per strobe.
module lim_boost_lane
    import lim_pkg::*;
#(
    parameter int BOOST_W = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  lim_phase_e         phase_i,
    input  logic               tick_i,
    input  logic [BOOST_W-1:0] user_i,
    output logic [BOOST_W-1:0] q_o
);

    logic [BOOST_W-1:0] stepped;
    logic [BOOST_W-1:0] nxt;

    // Apply one step for the current phase, then clamp to the user level.
    always_comb begin
        stepped = q_o;
        if (tick_i && (phase_i == PH_CUT_TONE) && (q_o != '0))
            stepped = q_o - 1'b1;
        else if (tick_i && (phase_i == PH_REL_TONE) && (q_o < user_i))
            stepped = q_o + 1'b1;
        nxt = (stepped > user_i) ? user_i : stepped;
    end

    // Hold the effective boost; follow the user value while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else if (!en_i)
            q_o <= user_i;
        else
            q_o <= nxt;
    end

    // R9: the effective boost never exceeds the user level one edge later.
    p_boost_ceiling_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> (q_o <= $past(user_i)));

endmodule

// File: rtl/lim_att_lane.sv
// Module: lim_att_lane
// Effective attenuation register. It rises by one code on attack ticks in
// the add-attenuation phase, saturating at the maximum code, and falls by
// one code on release ticks in the release-attenuation phase. It is clamped
// so that it never goes below the user level.
// Assumes: tick_i is at most one cycle wide per strobe.
module lim_att_lane
    import lim_pkg::*;
#(
    parameter int ATT_W = 7
) (
    input  logic             clk,
    input  logic             rst_n,
    input  logic             en_i,
    input  lim_phase_e       phase_i,
    input  logic             tick_i,
    input  logic [ATT_W-1:0] user_i,
    output logic [ATT_W-1:0] q_o
);

    localparam logic [ATT_W-1:0] ATT_MAX = {ATT_W{1'b1}};

    logic [ATT_W-1:0] stepped;
    logic [ATT_W-1:0] nxt;

    // Apply one step for the current phase, then clamp to the user floor.
    always_comb begin
        stepped = q_o;
        if (tick_i && (phase_i == PH_ADD_ATT) && (q_o != ATT_MAX))
            stepped = q_o + 1'b1;
        else if (tick_i && (phase_i == PH_REL_ATT) && (q_o > user_i))
            stepped = q_o - 1'b1;
        nxt = (stepped < user_i) ? user_i : stepped;
    end

    // Hold the effective attenuation; follow the user value while disabled.
    always_ff @(posedge clk) begin
        if (!rst_n)
            q_o <= '0;
        else if (!en_i)
            q_o <= user_i;
        else
            q_o <= nxt;
    end

    // R9: the effective attenuation never falls below the user level.
    p_att_floor_r9: assert property (@(posedge clk) disable iff (!rst_n)
        en_i |=> (q_o >= $past(user_i)));

    // R2: attenuation holds while the tone boost is still being cut.
    p_att_hold_cut_r2: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && (phase_i == PH_CUT_TONE) && (q_o >= user_i))
        |=> ((q_o == $past(q_o)) || (q_o == $past(user_i))));

endmodule

// File: rtl/peak_limiter_seq.sv
// Module: peak_limiter_seq (top)
// Peak limiter gain sequencer. It samples the clip flag on each strobe,
// selects a phase (cut tone, add attenuation, release attenuation, release
// tone), paces steps with a prescaler and drives the effective gains. While
// disabled, the user gains pass straight through to the outputs.
// Assumes: strobe_i is a one-cycle pulse followed by at least one idle cycle.
module peak_limiter_seq
    import lim_pkg::*;
#(
    parameter int BOOST_W = 4,
    parameter int ATT_W   = 7,
    parameter int RATE_W  = 4
) (
    input  logic               clk,
    input  logic               rst_n,
    input  logic               en_i,
    input  logic               strobe_i,
    input  logic               clip_i,
    input  logic [BOOST_W-1:0] user_bass_i,
    input  logic [BOOST_W-1:0] user_treb_i,
    input  logic [ATT_W-1:0]   user_att_i,
    input  logic [RATE_W-1:0]  atk_rate_i,
    input  logic [RATE_W-1:0]  rel_rate_i,
    output logic [BOOST_W-1:0] bass_o,
    output logic [BOOST_W-1:0] treb_o,
    output logic [ATT_W-1:0]   att_o,
    output logic               done_o
);

    localparam int NUM_BOOST = 2;
    localparam int LANE_BASS = 0;
    localparam int LANE_TREB = 1;

    logic               clip_q;
    lim_phase_e         phase;
    logic               tick;
    logic [BOOST_W-1:0] boost_user [NUM_BOOST];
    logic [BOOST_W-1:0] boost_q    [NUM_BOOST];
    logic [ATT_W-1:0]   att_q;

    // Gather the user boost levels into lane order.
    always_comb begin
        boost_user[LANE_BASS] = user_bass_i;
        boost_user[LANE_TREB] = user_treb_i;
    end

    // Capture the clip flag of each sample on its strobe.
    always_ff @(posedge clk) begin
        if (!rst_n)
            clip_q <= 1'b0;
        else if (strobe_i)
            clip_q <= clip_i;
    end

    lim_phase_sel #(
        .BOOST_W   (BOOST_W),
        .ATT_W     (ATT_W),
        .NUM_BOOST (NUM_BOOST)
    ) u_phase (
        .en_i         (en_i),
        .clip_q_i     (clip_q),
        .boost_q_i    (boost_q),
        .boost_user_i (boost_user),
        .att_q_i      (att_q),
        .att_user_i   (user_att_i),
        .phase_o      (phase)
    );

    lim_pacer #(
        .RATE_W (RATE_W)
    ) u_pacer (
        .clk        (clk),
        .rst_n      (rst_n),
        .phase_i    (phase),
        .strobe_i   (strobe_i),
        .atk_rate_i (atk_rate_i),
        .rel_rate_i (rel_rate_i),
        .tick_o     (tick)
    );

    for (genvar g = 0; g < NUM_BOOST; g++) begin : g_boost
        lim_boost_lane #(
            .BOOST_W (BOOST_W)
        ) u_lane (
            .clk     (clk),
            .rst_n   (rst_n),
            .en_i    (en_i),
            .phase_i (phase),
            .tick_i  (tick),
            .user_i  (boost_user[g]),
            .q_o     (boost_q[g])
        );
    end

    lim_att_lane #(
        .ATT_W (ATT_W)
    ) u_att (
        .clk     (clk),
        .rst_n   (rst_n),
        .en_i    (en_i),
        .phase_i (phase),
        .tick_i  (tick),
        .user_i  (user_att_i),
        .q_o     (att_q)
    );

    // Drive the outputs: pass-through when disabled, limited values otherwise.
    always_comb begin
        bass_o = en_i ? boost_q[LANE_BASS] : user_bass_i;
        treb_o = en_i ? boost_q[LANE_TREB] : user_treb_i;
        att_o  = en_i ? att_q : user_att_i;
        done_o = !clip_q && (bass_o == user_bass_i) && (treb_o == user_treb_i)
                 && (att_o == user_att_i);
    end

    // R3: attenuation only climbs by limiting once both boosts were zero under clip.
    p_att_after_tone_r3: assert property (@(posedge clk) disable iff (!rst_n)
        ($past(en_i) && en_i && (att_q > $past(att_q)) && (att_q > $past(user_att_i)))
        |-> ($past(clip_q) && ($past(boost_q[LANE_BASS]) == '0)
             && ($past(boost_q[LANE_TREB]) == '0)));

    // R5: bass boost holds while attenuation is still being released.
    p_tone_hold_rel_r5: assert property (@(posedge clk) disable iff (!rst_n)
        (en_i && !clip_q && (att_q > user_att_i))
        |=> ((boost_q[LANE_BASS] == $past(boost_q[LANE_BASS]))
             || (boost_q[LANE_BASS] == $past(user_bass_i))));

endmodule

// File: tb/sim_peak_limiter_seq.sv
// Bench for peak_limiter_seq: a vector table walked by one loop, then
// directed tests for reset, pass-through, clamping, saturation and pacing.
module sim_peak_limiter_seq;

    localparam int CLK_PERIOD = 10;
    localparam int NVEC       = 13;

    typedef struct packed {
        logic [3:0] ub;
        logic [3:0] ut;
        logic [6:0] ua;
        logic [3:0] atk;
        logic [3:0] rel;
        logic       clip;
        logic [7:0] n;
        logic [3:0] eb;
        logic [3:0] et;
        logic [6:0] ea;
        logic       ed;
    } vec_t;

    // Rows apply cumulatively from the state left by the row before.
    localparam vec_t VEC [NVEC] = '{
        '{4'd6, 4'd3, 7'd10, 4'd0, 4'd0, 1'b1, 8'd4,  4'd3, 4'd0, 7'd10, 1'b0},
        '{4'd6, 4'd3, 7'd10, 4'd0, 4'd0, 1'b1, 8'd4,  4'd0, 4'd0, 7'd11, 1'b0},
        '{4'd6, 4'd3, 7'd10, 4'd0, 4'd0, 1'b0, 8'd4,  4'd1, 4'd1, 7'd10, 1'b0},
        '{4'd6, 4'd3, 7'd10, 4'd0, 4'd0, 1'b0, 8'd3,  4'd4, 4'd3, 7'd10, 1'b0},
        '{4'd6, 4'd3, 7'd10, 4'd0, 4'd0, 1'b0, 8'd2,  4'd6, 4'd3, 7'd10, 1'b1},
        '{4'd6, 4'd3, 7'd10, 4'd1, 4'd0, 1'b1, 8'd5,  4'd4, 4'd1, 7'd10, 1'b0},
        '{4'd6, 4'd3, 7'd10, 4'd1, 4'd1, 1'b0, 8'd5,  4'd6, 4'd3, 7'd10, 1'b1},
        '{4'd6, 4'd3, 7'd10, 4'd0, 4'd0, 1'b1, 8'd10, 4'd0, 4'd0, 7'd13, 1'b0},
        '{4'd6, 4'd3, 7'd10, 4'd0, 4'd0, 1'b0, 8'd3,  4'd0, 4'd0, 7'd12, 1'b0},
        '{4'd6, 4'd3, 7'd10, 4'd0, 4'd0, 1'b1, 8'd2,  4'd0, 4'd0, 7'd12, 1'b0},
        '{4'd6, 4'd3, 7'd10, 4'd0, 4'd0, 1'b0, 8'd5,  4'd1, 4'd1, 7'd10, 1'b0},
        '{4'd6, 4'd3, 7'd10, 4'd0, 4'd0, 1'b1, 8'd3,  4'd0, 4'd0, 7'd10, 1'b0},
        '{4'd6, 4'd3, 7'd10, 4'd0, 4'd0, 1'b0, 8'd8,  4'd6, 4'd3, 7'd10, 1'b1}
    };

    logic       clk = 1'b0;
    logic       rst_n;
    logic       en;
    logic       strobe;
    logic       clip;
    logic [3:0] ubass;
    logic [3:0] utreb;
    logic [6:0] uatt;
    logic [3:0] atk;
    logic [3:0] rel;
    logic [3:0] bass;
    logic [3:0] treb;
    logic [6:0] att;
    logic       done;

    int checks   = 0;
    int failures = 0;
    bit finished = 1'b0;

    peak_limiter_seq u0 (
        .clk         (clk),
        .rst_n       (rst_n),
        .en_i        (en),
        .strobe_i    (strobe),
        .clip_i      (clip),
        .user_bass_i (ubass),
        .user_treb_i (utreb),
        .user_att_i  (uatt),
        .atk_rate_i  (atk),
        .rel_rate_i  (rel),
        .bass_o      (bass),
        .treb_o      (treb),
        .att_o       (att),
        .done_o      (done)
    );

    always #(CLK_PERIOD / 2) clk = ~clk;

    // Requirement tags exercised by each table row.
    function automatic string row_req(input int i);
        case (i)
            0:       return "R2 R11";
            1:       return "R2 R3";
            2:       return "R5 R6";
            3:       return "R6";
            4:       return "R6 R10";
            5:       return "R4 R2";
            6:       return "R7 R10";
            7:       return "R2 R3";
            8:       return "R5";
            9:       return "R8 R11";
            10:      return "R5 R6";
            11:      return "R8 R2";
            default: return "R6 R10";
        endcase
    endfunction

    task automatic chk(input string req, input logic [3:0] eb, input logic [3:0] et,
                       input logic [6:0] ea, input logic ed);
        checks++;
        if (bass !== eb || treb !== et || att !== ea || done !== ed) begin
            failures++;
            $display("FAIL %s: bass=%0d treb=%0d att=%0d done=%0d expected bass=%0d treb=%0d att=%0d done=%0d",
                     req, bass, treb, att, done, eb, et, ea, ed);
        end
    endtask

    task automatic pulse_strobes(input int n);
        for (int i = 0; i < n; i++) begin
            @(negedge clk) strobe = 1'b1;
            @(negedge clk) strobe = 1'b0;
        end
        @(negedge clk);
    endtask

    task automatic finish_run;
        if (!finished) begin
            finished = 1'b1;
            $display("TB_RESULT checks=%0d failures=%0d", checks, failures);
            $finish;
        end
    endtask

    // Watchdog: a hung run counts as a failed check and still reports.
    initial begin
        repeat (100000) @(posedge clk);
        checks++;
        failures++;
        $display("FAIL watchdog: run did not end, expected completion");
        finish_run();
    end

    initial begin
        rst_n  = 1'b0;
        en     = 1'b0;
        strobe = 1'b0;
        clip   = 1'b0;
        ubass  = 4'd6;
        utreb  = 4'd3;
        uatt   = 7'd10;
        atk    = 4'd0;
        rel    = 4'd0;

        // R1: pass-through during reset; R10: done with no clip sampled.
        @(negedge clk);
        chk("R1 reset", 4'd6, 4'd3, 7'd10, 1'b1);
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        @(negedge clk);
        chk("R1 after reset", 4'd6, 4'd3, 7'd10, 1'b1);

        // R1: disabled limiter ignores clipping and follows user values at once.
        clip = 1'b1;
        pulse_strobes(3);
        ubass = 4'd9;
        utreb = 4'd2;
        uatt  = 7'd20;
        #1;
        chk("R1 R10 disabled clip", 4'd9, 4'd2, 7'd20, 1'b0);
        clip = 1'b0;
        pulse_strobes(1);
        chk("R10 clip cleared", 4'd9, 4'd2, 7'd20, 1'b1);

        // Table walk with the limiter enabled.
        ubass = 4'd6;
        utreb = 4'd3;
        uatt  = 7'd10;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        for (int i = 0; i < NVEC; i++) begin
            ubass = VEC[i].ub;
            utreb = VEC[i].ut;
            uatt  = VEC[i].ua;
            atk   = VEC[i].atk;
            rel   = VEC[i].rel;
            clip  = VEC[i].clip;
            pulse_strobes(int'(VEC[i].n));
            chk($sformatf("table row %0d %s", i, row_req(i)),
                VEC[i].eb, VEC[i].et, VEC[i].ea, VEC[i].ed);
        end

        // R9: new user values clamp the effective ones on the next edge.
        ubass = 4'd1;
        utreb = 4'd0;
        uatt  = 7'd125;
        @(negedge clk);
        chk("R9 clamp", 4'd1, 4'd0, 7'd125, 1'b1);

        // R3: attenuation saturates at code 127 after the boost is gone.
        clip = 1'b1;
        pulse_strobes(10);
        chk("R3 saturate", 4'd0, 4'd0, 7'd127, 1'b0);

        // R1: disabling mid-limit restores user values immediately.
        en = 1'b0;
        #1;
        chk("R1 disable mid-limit", 4'd1, 4'd0, 7'd125, 1'b0);
        repeat (2) @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        chk("R1 re-enable", 4'd1, 4'd0, 7'd125, 1'b0);
        clip = 1'b0;
        pulse_strobes(3);
        chk("R8 R6 recover", 4'd1, 4'd0, 7'd125, 1'b1);

        // R4: with attack code 2 the first cut lands on the 4th counted strobe.
        en   = 1'b0;
        rst_n = 1'b0;
        repeat (2) @(negedge clk);
        rst_n = 1'b1;
        ubass = 4'd4;
        utreb = 4'd4;
        uatt  = 7'd0;
        atk   = 4'd2;
        @(negedge clk);
        en = 1'b1;
        @(negedge clk);
        clip = 1'b1;
        pulse_strobes(4);
        chk("R4 before tick", 4'd4, 4'd4, 7'd0, 1'b0);
        pulse_strobes(1);
        chk("R4 on tick", 4'd3, 4'd3, 7'd0, 1'b0);

        finish_run();
    end

endmodule